// File: doc/BRIEF.md
# Multiprocessor UART Address Filter

This block sits after a UART receiver that delivers nine-bit characters. The ninth bit tells an address character apart from a data character. The filter compares each address character with a programmable local node address. From that comparison it decides which characters travel on to the host, which of them raise an interrupt, and which data byte opens a frame that has been accepted.

A two-bit mode input selects one of four behaviours:

- **Pass-through:** every character is forwarded.
- **Software-decided:** address characters are forwarded so that software can judge the match, and a software-held accept bit gates the data.
- **Hardware-filtered, address interrupts on:** frames for this node are forwarded and the matching address is forwarded with its interrupt.
- **Hardware-filtered, address interrupts off:** the same as the previous mode, but the matching address is consumed silently.

Each output is registered and appears one clock after the receiver's valid strobe.

Top module: `mpuart_addr_filter`

## Requirements
- R1: While reset is held and after it is released, out_valid, irq and first_of_frame are 0 and no frame is accepted. In modes 2 and 3, data characters that arrive before any matching address are dropped.
- R2: In mode 0 (filter_mode = 2'b00), every character with rx_valid=1 is forwarded one cycle later with irq=1 and first_of_frame=0.
- R3: In mode 1 (2'b01), every address character is forwarded with irq. A data character is forwarded with irq only if sw_accept=1 in the cycle it arrives. first_of_frame stays 0.
- R4: A character is an address when rx_is_addr=1, and it matches when rx_char equals node_addr on all 8 bits. In mode 2 (2'b10), a matching address is forwarded with irq=1.
- R5: In modes 2 and 3, an address that does not match is not forwarded. Every data character after it is dropped until a matching address arrives.
- R6: In modes 2 and 3, data characters that follow a matching address are forwarded with irq=1 until the next address character.
- R7: In modes 2 and 3, the first forwarded data character after a matching address has first_of_frame=1, and the later data characters of that frame have first_of_frame=0.
- R8: In mode 3 (2'b11), a matching address character is not forwarded and raises no interrupt, yet it still opens the frame.
- R9: A forwarded character appears on out_data exactly one cycle after its rx_valid strobe. irq and first_of_frame are high only together with out_valid, and each is a one-cycle pulse for that character.
- R10: Every address character updates the match state in every mode. After a switch to mode 2 or 3, the frame opened by the last address is therefore still honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filter_mode | input | 2 | Filtering behaviour selector |
| node_addr | input | 8 | Local address for comparison |
| sw_accept | input | 1 | Software accept bit for mode 1 data |
| rx_char | input | 8 | Received character, low 8 bits |
| rx_is_addr | input | 1 | Ninth bit: 1 marks an address character |
| rx_valid | input | 1 | One-cycle strobe for rx_char |
| out_data | output | 8 | Forwarded character |
| out_valid | output | 1 | out_data holds a forwarded character |
| irq | output | 1 | Interrupt pulse for the forwarded character |
| first_of_frame | output | 1 | Marks the first data byte of an accepted frame |

## Verification
The block keeps two bits of state: whether a frame is accepted, and whether the opening byte of that frame is still pending. If the acceptance bit is wrong, the next data character in mode 2 or 3 is either lost or leaks through, so the error shows on out_valid one clock after that character. If the pending bit is wrong, first_of_frame goes missing, is doubled, or lands on the wrong byte, and this shows on the first data byte after an address. Because of this, the stimulus mixes matching and foreign addresses with runs of data and with switches of mode in the middle of a frame.

// File: rtl/mpuart_addr_filter.sv
module mpuart_addr_filter #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        filter_mode,
  input  logic [CHAR_W-1:0] node_addr,
  input  logic              sw_accept,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_is_addr,
  input  logic              rx_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_valid,
  output logic              irq,
  output logic              first_of_frame
);

  localparam logic [1:0] MODE_ALL  = 2'b00;
  localparam logic [1:0] MODE_SW   = 2'b01;
  localparam logic [1:0] MODE_HWI  = 2'b10;

  logic in_frame, open_pending;
  logic hit, fwd, tag_first;

  assign hit = rx_is_addr && (rx_char == node_addr);

  always_comb begin
    fwd = 1'b0;
    if (rx_valid) begin
      unique case (filter_mode)
        MODE_ALL: fwd = 1'b1;
        MODE_SW:  fwd = rx_is_addr || sw_accept;
        MODE_HWI: fwd = rx_is_addr ? hit : in_frame;
        default:  fwd = !rx_is_addr && in_frame;
      endcase
    end
  end

  assign tag_first = fwd && !rx_is_addr && filter_mode[1] && open_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame       <= 1'b0;
      open_pending   <= 1'b0;
      out_valid      <= 1'b0;
      irq            <= 1'b0;
      first_of_frame <= 1'b0;
      out_data       <= '0;
    end else begin
      if (rx_valid && rx_is_addr) begin
        in_frame     <= hit;
        open_pending <= hit;
      end else if (tag_first) begin
        open_pending <= 1'b0;
      end
      out_valid      <= fwd;
      irq            <= fwd;
      first_of_frame <= tag_first;
      if (fwd) out_data <= rx_char;
    end
  end

  // R9
  irq_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> out_valid);

  // R9
  first_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_of_frame |-> out_valid);

  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !out_valid);

  // R2
  pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && filter_mode == MODE_ALL) |=> (out_valid && irq && !first_of_frame));

  // R5
  foreign_addr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_is_addr && rx_char != node_addr && filter_mode[1]) |=> !out_valid);

  // R8
  silent_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_is_addr && filter_mode == 2'b11) |=> !out_valid);

  // R7
  first_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_is_addr) |=> !first_of_frame);

endmodule

// File: tb/mpuart_addr_filter_test.sv
module mpuart_addr_filter_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] filter_mode = 0;
  logic [7:0] node_addr = 8'h5A;
  logic sw_accept = 0;
  logic [7:0] rx_char = 0;
  logic rx_is_addr = 0, rx_valid = 0;
  logic [7:0] out_data;
  logic out_valid, irq, first_of_frame;

  int vectors = 0, errors = 0, cycles = 0;
  bit m_acc = 0, m_pend = 0;
  bit e_v = 0, e_f = 0;
  logic [7:0] e_d = 0;
  string e_tag = "R1";

  always #5 clk = ~clk;

  mpuart_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .filter_mode(filter_mode), .node_addr(node_addr),
    .sw_accept(sw_accept), .rx_char(rx_char), .rx_is_addr(rx_is_addr),
    .rx_valid(rx_valid), .out_data(out_data), .out_valid(out_valid),
    .irq(irq), .first_of_frame(first_of_frame));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic check_out();
    vectors++;
    if (out_valid !== e_v || irq !== e_v || first_of_frame !== e_f ||
        (e_v && out_data !== e_d)) begin
      errors++;
      $display("FAIL %s: actual v=%0b irq=%0b first=%0b data=%h expected v=%0b irq=%0b first=%0b data=%h",
               e_tag, out_valid, irq, first_of_frame, out_data, e_v, e_v, e_f, e_d);
    end
  endtask

  task automatic apply(input bit v, input bit a, input logic [7:0] c,
                       input logic [1:0] m, input bit sw);
    bit hit, fv;
    @(negedge clk);
    check_out();
    rx_valid = v; rx_is_addr = a; rx_char = c; filter_mode = m; sw_accept = sw;
    hit = a && (c == node_addr);
    fv = 0;
    if (v) case (m)
      2'b00: fv = 1;
      2'b01: fv = a || sw;
      2'b10: fv = a ? hit : m_acc;
      default: fv = !a && m_acc;
    endcase
    e_v = fv; e_d = c;
    e_f = fv && !a && m[1] && m_pend;
    if (!v) e_tag = "R9";
    else if (m == 2'b00) e_tag = "R2";
    else if (m == 2'b01) e_tag = "R3";
    else if (a && hit) e_tag = (m == 2'b11) ? "R8" : "R4";
    else if (a) e_tag = "R5";
    else if (e_f) e_tag = "R7";
    else if (m_acc) e_tag = "R6";
    else e_tag = "R5";
    if (v && a) begin m_acc = hit; m_pend = hit; end
    else if (e_f) m_pend = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    e_tag = "R1"; check_out();
    rst_n = 1;
    // R1: data before any address dropped
    apply(1, 0, 8'h11, 2'b10, 0);
    apply(1, 0, 8'h12, 2'b11, 0);
    // R4 / R7 / R6
    apply(1, 1, 8'h5A, 2'b10, 0);
    apply(1, 0, 8'hA1, 2'b10, 0);
    apply(1, 0, 8'hA2, 2'b10, 0);
    // R5 foreign address, data dropped
    apply(1, 1, 8'h5B, 2'b10, 0);
    apply(1, 0, 8'hA3, 2'b10, 0);
    // R8 silent matching address, first flag kept
    apply(1, 1, 8'h5A, 2'b11, 0);
    apply(0, 0, 8'h00, 2'b11, 0);
    apply(1, 0, 8'hB1, 2'b11, 0);
    apply(1, 0, 8'hB2, 2'b11, 0);
    // R10: address seen in mode 0 honoured after switching to mode 3
    apply(1, 1, 8'h5A, 2'b00, 0);
    apply(1, 0, 8'hC1, 2'b11, 0);
    apply(1, 1, 8'h33, 2'b01, 1);
    apply(1, 0, 8'hC2, 2'b10, 0);
    // R3: sw_accept gating
    apply(1, 0, 8'hD1, 2'b01, 0);
    apply(1, 0, 8'hD2, 2'b01, 1);
    // R2
    apply(1, 0, 8'hE1, 2'b00, 0);
    apply(1, 1, 8'hE2, 2'b00, 0);
    for (int seg = 0; seg < 40; seg++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      for (int k = 0; k < 200; k++) begin
        bit a;
        logic [7:0] c;
        a = ($urandom_range(0, 5) == 0);
        c = (a && $urandom_range(0, 1) == 1) ? node_addr : 8'($urandom);
        apply($urandom_range(0, 3) != 0, a, c, m, 1'($urandom));
      end
    end
    apply(0, 0, 8'h00, 2'b00, 0);
    @(negedge clk);
    check_out();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule